// File: doc/BRIEF.md
# Converter Auto-Trigger Start Selector

This block decides when an analog-to-digital conversion begins while the converter runs in automatic trigger mode. A set of level event flags (an analog comparator output, an external interrupt request, a timer compare-match flag) and the converter's own conversion-complete flag feed a multiplexer. A 3-bit source code picks one of them. The block registers the chosen signal every cycle and emits a one-cycle start pulse when it sees that signal go from low to high.

The edge is detected after the multiplexer. Because of this, changing the source code from a low flag to a high flag also counts as a rising edge and starts a conversion. The one exception is a switch to the free-running code: it never starts a conversion. In free-running mode the converter restarts itself on each rising edge of its conversion-complete flag. Starts are suppressed when automatic triggering is off, when the converter is disabled, or while a conversion is still in progress.

Top module: `adc_trig_select`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `start_o` is 0.
- R2: Source codes on `src_sel` map to signals as follows. Code 0 selects `conv_done`. Code 1 selects `evt_flags[0]` (comparator). Code 2 selects `evt_flags[1]` (external interrupt). Code 3 selects `evt_flags[2]` (timer compare match). The selected signal is sampled at each rising clock edge. If a sample is 1 and the sample before it was 0, `start_o` is 1 for the clock cycle that follows that edge, provided the other conditions below allow a start.
- R3: Rising edges on flags that are not selected produce no start.
- R4: Codes 4 to 7 select a constant 0. While such a code is held, no start is produced, whatever the flags do.
- R5: While `auto_en` is 0, no start is produced.
- R6: While `conv_en` is 0, no start is produced.
- R7: An edge sampled while `conv_busy` is 1 is discarded. It does not cause a start in a later cycle.
- R8: Changing `src_sel` from a source whose signal is 0 to one whose signal is 1 counts as a rising edge and produces a start.
- R9: Changing `src_sel` from a nonzero code to code 0 never produces a start in that cycle, even if `conv_done` is 1.
- R10: With code 0 held, a rising edge of `conv_done` produces a start.
- R11: `start_o` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic trigger mode enable |
| conv_en | input | 1 | Converter enable |
| conv_busy | input | 1 | Conversion in progress |
| src_sel | input | 3 | Trigger source code |
| evt_flags | input | NUM_EVT (3) | Event flags: comparator, external interrupt, timer match |
| conv_done | input | 1 | Conversion-complete flag |
| start_o | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and is held at 0 during reset. They also assume that `conv_busy` and the flags are levels and not pulses narrower than a cycle. In addition, the properties on the enables and on code switches only hold if the inputs are sampled on the same edge the design uses. To keep within these assumptions, the stimulus changes inputs only on falling clock edges, applies exactly one input vector per cycle, and holds every input at 0 through reset.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    TRG_FREERUN     = 3'd0,
    TRG_COMPARE     = 3'd1,
    TRG_EXTIRQ      = 3'd2,
    TRG_TIMER_MATCH = 3'd3
  } trg_src_e;

endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int SEL_W   = adc_trig_pkg::SEL_W,
  parameter int NUM_EVT = 3
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_EVT-1:0] evt_flags,
  input  logic               conv_done,
  output logic               sel_sig
);
  localparam int NUM_CODES = 1 << SEL_W;

  logic [NUM_CODES-1:0] cand;

  // Candidate per code: 0 is the completion flag, 1..NUM_EVT the events,
  // remaining codes tie low.
  for (genvar k = 0; k < NUM_CODES; k++) begin : g_cand
    if (k == 0) begin : g_free
      assign cand[k] = conv_done;
    end else if (k <= NUM_EVT) begin : g_evt
      assign cand[k] = evt_flags[k-1];
    end else begin : g_none
      assign cand[k] = 1'b0;
    end
  end

  assign sel_sig = cand[sel];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int SEL_W = adc_trig_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_sig,
  output logic             rise,
  output logic             to_freerun
);
  import adc_trig_pkg::*;

  logic             prev_sig_q, prev_sig_d;
  logic [SEL_W-1:0] prev_sel_q, prev_sel_d;
  logic             smp_en;

  // History is sampled every cycle so that select switches form edges.
  assign smp_en = 1'b1;

  always_comb begin
    prev_sig_d = prev_sig_q;
    prev_sel_d = prev_sel_q;
    if (smp_en) begin
      prev_sig_d = sel_sig;
      prev_sel_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sig_q <= 1'b0;
      prev_sel_q <= '0;
    end else begin
      prev_sig_q <= prev_sig_d;
      prev_sel_q <= prev_sel_d;
    end
  end

  assign rise       = sel_sig & ~prev_sig_q;
  assign to_freerun = (sel == SEL_W'(TRG_FREERUN)) && (prev_sel_q != SEL_W'(TRG_FREERUN));
endmodule

// File: rtl/trig_start_gate.sv
module trig_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic to_freerun,
  input  logic auto_en,
  input  logic conv_en,
  input  logic conv_busy,
  output logic start_o
);
  logic fire;
  logic start_q, start_d;

  always_comb begin
    fire    = rise & ~to_freerun & auto_en & conv_en & ~conv_busy;
    start_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign start_o = start_q;
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select #(
  parameter int SEL_W   = adc_trig_pkg::SEL_W,
  parameter int NUM_EVT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               auto_en,
  input  logic               conv_en,
  input  logic               conv_busy,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [NUM_EVT-1:0] evt_flags,
  input  logic               conv_done,
  output logic               start_o
);
  logic sel_sig;
  logic rise;
  logic to_freerun;

  trig_src_mux #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_mux (
    .sel       (src_sel),
    .evt_flags (evt_flags),
    .conv_done (conv_done),
    .sel_sig   (sel_sig)
  );

  trig_edge_det #(.SEL_W(SEL_W)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (src_sel),
    .sel_sig    (sel_sig),
    .rise       (rise),
    .to_freerun (to_freerun)
  );

  trig_start_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .to_freerun (to_freerun),
    .auto_en    (auto_en),
    .conv_en    (conv_en),
    .conv_busy  (conv_busy),
    .start_o    (start_o)
  );
endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk #(
  parameter int SEL_W   = 3,
  parameter int NUM_EVT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               auto_en,
  input logic               conv_en,
  input logic               conv_busy,
  input logic [SEL_W-1:0]   src_sel,
  input logic [NUM_EVT-1:0] evt_flags,
  input logic               conv_done,
  input logic               start_o
);
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (start_o == 1'b0);
    end
  end

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R5
  auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !start_o);

  // R6
  conv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !start_o);

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !start_o);

  // R9
  freerun_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == '0 && $past(src_sel) != '0) |=> !start_o);

  // R4
  unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(src_sel) > NUM_EVT && $stable(src_sel)) |=> !start_o);
endmodule

bind adc_trig_select adc_trig_chk #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .auto_en   (auto_en),
  .conv_en   (conv_en),
  .conv_busy (conv_busy),
  .src_sel   (src_sel),
  .evt_flags (evt_flags),
  .conv_done (conv_done),
  .start_o   (start_o)
);

// File: tb/adc_trig_select_test.sv
module adc_trig_select_test;
  logic       clk;
  logic       rst_n;
  logic       auto_en, conv_en, conv_busy, conv_done;
  logic [2:0] src_sel;
  logic [2:0] evt_flags;
  logic       start_o;

  int applied = 0;
  int miscompares = 0;
  logic  expq[$];
  string tagq[$];
  bit    done_flag = 0;

  adc_trig_select uut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .conv_en(conv_en),
    .conv_busy(conv_busy), .src_sel(src_sel), .evt_flags(evt_flags),
    .conv_done(conv_done), .start_o(start_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Driver: one vector per cycle, expectation for the cycle after the edge.
  task automatic step(input logic a, input logic e, input logic b,
                      input logic [2:0] s, input logic [2:0] f,
                      input logic d, input logic exp, input string tag);
    @(negedge clk);
    auto_en = a; conv_en = e; conv_busy = b;
    src_sel = s; evt_flags = f; conv_done = d;
    expq.push_back(exp);
    tagq.push_back(tag);
  endtask

  // Monitor: compares shortly after each rising edge.
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      logic  e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      applied++;
      if (start_o !== e) begin
        miscompares++;
        $display("FAIL %s: start_o=%b expected=%b", t, start_o, e);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      miscompares++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    auto_en = 0; conv_en = 0; conv_busy = 0; src_sel = 0; evt_flags = 0; conv_done = 0;
    repeat (3) @(posedge clk);
    #1;
    applied++;
    if (start_o !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: start_o=%b expected=0", start_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1: first cycle after release stays quiet
    step(1,1,0,3'd1,3'b000,0, 1'b0, "R1");
    step(1,1,0,3'd1,3'b001,0, 1'b1, "R2 comparator edge");
    step(1,1,0,3'd1,3'b001,0, 1'b0, "R11 held high");
    step(1,1,0,3'd1,3'b000,0, 1'b0, "R2 falling");
    step(1,1,0,3'd1,3'b110,0, 1'b0, "R3 unselected edges");
    step(1,1,0,3'd2,3'b110,0, 1'b1, "R8 switch to high source");
    step(1,1,0,3'd2,3'b000,0, 1'b0, "R11 after switch");
    step(1,1,0,3'd3,3'b100,0, 1'b1, "R2 timer match");
    step(1,1,0,3'd3,3'b000,0, 1'b0, "R2 timer low");
    step(0,1,0,3'd3,3'b100,0, 1'b0, "R5 auto off");
    step(1,1,0,3'd3,3'b000,0, 1'b0, "R5 recover low");
    step(1,0,0,3'd3,3'b100,0, 1'b0, "R6 converter off");
    step(1,1,0,3'd3,3'b000,0, 1'b0, "R6 recover low");
    step(1,1,1,3'd3,3'b100,0, 1'b0, "R7 busy edge");
    step(1,1,0,3'd3,3'b100,0, 1'b0, "R7 not deferred");
    step(1,1,0,3'd3,3'b000,0, 1'b0, "R7 low");
    step(1,1,0,3'd0,3'b000,1, 1'b0, "R9 switch to free-running");
    step(1,1,0,3'd0,3'b000,0, 1'b0, "R10 done low");
    step(1,1,0,3'd0,3'b000,1, 1'b1, "R10 done edge");
    step(1,1,0,3'd0,3'b000,0, 1'b0, "R11 after free-run start");
    step(1,1,0,3'd5,3'b111,0, 1'b0, "R4 code 5");
    step(1,1,0,3'd7,3'b111,1, 1'b0, "R4 code 7");
    step(1,1,0,3'd4,3'b000,0, 1'b0, "R4 code 4 low");
    step(1,1,0,3'd4,3'b111,0, 1'b0, "R4 code 4 flags high");
    step(1,1,0,3'd2,3'b111,0, 1'b1, "R8 from unused code");
    step(1,1,0,3'd2,3'b000,0, 1'b0, "R2 ext low");
    step(1,1,0,3'd2,3'b010,0, 1'b1, "R2 external interrupt edge");
    step(1,1,0,3'd2,3'b010,0, 1'b0, "R11 ext held");
    repeat (3) @(posedge clk);
    #2;
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule